// File: doc/BRIEF.md
# Framed PWM Generator with Latched High Override

The block produces a fixed-frequency pulse-width-modulated level from a 10-bit demand word. A period is built from twenty equal slots, and an external slot-tick enable moves the block from one slot to the next. A pulse of 400 kHz on that enable gives a period of 50 us. Every period opens with two slots that are always high and closes with two slots that are always low. The sixteen slots between them carry the modulated part of the pulse, and their high slots form one run that follows straight after the opening pair.

The demand word is read once per period, on the tick that wraps the slot counter back to slot 0. A change to the demand word therefore never alters a period that has already started. On that same wrap the block also gives a one-clock period-start strobe. A force input takes the output to a constant high level. The block latches that request, and the output stays high until the next reset.

Top module: `framed_pwm`

## Requirements
- R1: While reset is asserted and straight after it, the slot counter is at slot 0, the modulated high count is 0, the override is clear, `pwm_o` is 1 and `period_start_o` is 0.
- R2: The slot counter moves forward by one only in cycles where `slot_tick_i` is 1. It goes from slot 19 back to slot 0. With the tick low, the output pattern stays frozen.
- R3: When no override is latched, `pwm_o` is 1 during slots 0 and 1.
- R4: When no override is latched, `pwm_o` is 0 during slots 18 and 19.
- R5: The number of high slots among slots 2..17 is 0 for a demand of 0. For any other demand it is demand[9:6] + 1, so it ranges from 1 to 16. A demand of 0x3FF makes all sixteen slots high.
- R6: The modulated high slots form one contiguous run that starts at slot 2. With N of them, slots 2..N+1 are high and slots N+2..17 are low.
- R7: The demand word is taken only on the clock edge where `slot_tick_i` is 1 and the counter is at slot 19. The value it sets applies to the whole period that follows. Changes to the demand word at any other time have no effect. The first period after reset uses a count of 0.
- R8: `period_start_o` is 1 for exactly the one clock cycle after the wrapping edge, which is the first cycle spent at slot 0. It is 0 at every other time.
- R9: If `force_i` is 1 at a clock edge, `pwm_o` is 1 from the next cycle onward, whatever the slot or demand, until reset. The slot counting and `period_start_o` carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_tick_i | input | 1 | Enable that advances the slot counter by one |
| demand_i | input | 10 | Duty demand, read at the start of each period |
| force_i | input | 1 | Latches a constant-high override |
| pwm_o | output | 1 | PWM level |
| period_start_o | output | 1 | One-cycle strobe at the start of each period |

## Verification
All state changes on a clock edge, and both outputs are decoded directly from registers. Because of this, every result is due one cycle after the edge that carried its stimulus. That applies to a tick moving the slot, a wrap taking in the demand word and raising the strobe, and a force request setting the latch. The bench drives its inputs on the falling edge and applies the same edge rules to its own model on the rising edge. It then compares both outputs at the next falling edge, so each comparison looks at the first cycle in which the new value is due. The directed cases hold the tick low for long stretches, change the demand word part way through a period, and issue a force request that is followed by a reset.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  typedef enum logic [1:0] {
    REG_LEAD = 2'd0,
    REG_MID  = 2'd1,
    REG_TAIL = 2'd2
  } slot_region_e;
endpackage

// File: rtl/fpwm_slot_ctr.sv
module fpwm_slot_ctr #(
  parameter int NUM_SLOTS = 20,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              wrap_o,
  output logic              start_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic              start_q;

  assign wrap_o = tick_i && (slot_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= wrap_o;
      if (wrap_o)      slot_q <= '0;
      else if (tick_i) slot_q <= slot_q + 1'b1;
    end
  end

  assign slot_o  = slot_q;
  assign start_o = start_q;
endmodule

// File: rtl/fpwm_duty_sampler.sv
module fpwm_duty_sampler #(
  parameter int DEMAND_W  = 10,
  parameter int MID_SLOTS = 16,
  localparam int CODE_BITS = $clog2(MID_SLOTS),
  localparam int CNT_W     = CODE_BITS + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [DEMAND_W-1:0] demand_i,
  output logic [CNT_W-1:0]    cnt_o
);
  logic [CODE_BITS-1:0] code;
  logic [CNT_W-1:0]     inc;
  logic [CNT_W-1:0]     target;
  logic [CNT_W-1:0]     cnt_q;

  assign code = demand_i[DEMAND_W-1 -: CODE_BITS];
  assign inc  = {1'b0, code} + 1'b1;

  always_comb begin
    if (demand_i == '0)                 target = '0;
    else if (inc > CNT_W'(MID_SLOTS))   target = CNT_W'(MID_SLOTS);
    else                                target = inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= target;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fpwm_shaper.sv
module fpwm_shaper
  import fpwm_pkg::*;
#(
  parameter int NUM_SLOTS  = 20,
  parameter int LEAD_SLOTS = 2,
  parameter int MID_SLOTS  = 16,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int CNT_W  = $clog2(MID_SLOTS) + 1,
  localparam int SUM_W  = (SLOT_W > CNT_W ? SLOT_W : CNT_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              force_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              pwm_o
);
  slot_region_e region;
  logic [SUM_W-1:0] slot_x;
  logic [SUM_W-1:0] mid_end;
  logic             mid_high;
  logic             force_q;

  assign slot_x  = SUM_W'(slot_i);
  assign mid_end = SUM_W'(LEAD_SLOTS) + SUM_W'(cnt_i);

  always_comb begin
    if (slot_x < SUM_W'(LEAD_SLOTS))                  region = REG_LEAD;
    else if (slot_x < SUM_W'(LEAD_SLOTS + MID_SLOTS)) region = REG_MID;
    else                                               region = REG_TAIL;
  end

  assign mid_high = (slot_x < mid_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      force_q <= 1'b0;
    else if (force_i) force_q <= 1'b1;
  end

  always_comb begin
    unique case (region)
      REG_LEAD: pwm_o = 1'b1;
      REG_MID:  pwm_o = mid_high;
      default:  pwm_o = 1'b0;
    endcase
    if (force_q) pwm_o = 1'b1;
  end
endmodule

// File: rtl/framed_pwm.sv
module framed_pwm #(
  parameter int DEMAND_W   = 10,
  parameter int LEAD_SLOTS = 2,
  parameter int MID_SLOTS  = 16,
  parameter int TAIL_SLOTS = 2,
  localparam int NUM_SLOTS = LEAD_SLOTS + MID_SLOTS + TAIL_SLOTS,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int CNT_W     = $clog2(MID_SLOTS) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                slot_tick_i,
  input  logic [DEMAND_W-1:0] demand_i,
  input  logic                force_i,
  output logic                pwm_o,
  output logic                period_start_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [CNT_W-1:0]  mid_cnt_q;
  logic              wrap;

  fpwm_slot_ctr #(.NUM_SLOTS(NUM_SLOTS)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (slot_tick_i),
    .slot_o  (slot_q),
    .wrap_o  (wrap),
    .start_o (period_start_o)
  );

  fpwm_duty_sampler #(.DEMAND_W(DEMAND_W), .MID_SLOTS(MID_SLOTS)) u_duty (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (wrap),
    .demand_i (demand_i),
    .cnt_o    (mid_cnt_q)
  );

  fpwm_shaper #(
    .NUM_SLOTS (NUM_SLOTS),
    .LEAD_SLOTS(LEAD_SLOTS),
    .MID_SLOTS (MID_SLOTS)
  ) u_shape (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .force_i (force_i),
    .slot_i  (slot_q),
    .cnt_i   (mid_cnt_q),
    .pwm_o   (pwm_o)
  );
endmodule

// File: rtl/framed_pwm_sva.sv
module framed_pwm_sva #(
  parameter int SLOT_W = 5,
  parameter int CNT_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              slot_tick_i,
  input logic              force_i,
  input logic              pwm_o,
  input logic              period_start_o,
  input logic [SLOT_W-1:0] slot_i,
  input logic [CNT_W-1:0]  mid_cnt_i
);
  logic forced_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      forced_q <= 1'b0;
    else if (force_i) forced_q <= 1'b1;
  end

  assert_slot_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_tick_i |=> $stable(slot_i));

  assert_slot_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i <= SLOT_W'(19));

  assert_lead_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i < SLOT_W'(2)) |-> pwm_o);

  assert_tail_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i >= SLOT_W'(18) && !forced_q) |-> !pwm_o);

  assert_cnt_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(slot_tick_i && slot_i == SLOT_W'(19)) |=> $stable(mid_cnt_i));

  assert_start_at_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_o |-> (slot_i == '0));

  assert_start_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_o |=> !period_start_o);

  assert_force_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    forced_q |-> pwm_o);
endmodule

bind framed_pwm framed_pwm_sva #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_sva (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .slot_tick_i    (slot_tick_i),
  .force_i        (force_i),
  .pwm_o          (pwm_o),
  .period_start_o (period_start_o),
  .slot_i         (slot_q),
  .mid_cnt_i      (mid_cnt_q)
);

// File: tb/framed_pwm_test.sv
module framed_pwm_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       slot_tick_i = 1'b0;
  logic [9:0] demand_i = '0;
  logic       force_i = 1'b0;
  logic       pwm_o;
  logic       period_start_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  int m_slot, m_cnt;
  bit m_force, m_ps;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  framed_pwm uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .slot_tick_i(slot_tick_i),
    .demand_i(demand_i), .force_i(force_i),
    .pwm_o(pwm_o), .period_start_o(period_start_o)
  );

  function automatic int exp_cnt(logic [9:0] d);
    return (d == 0) ? 0 : int'(d[9:6]) + 1;
  endfunction

  function automatic bit exp_pwm();
    return m_force || (m_slot < 2) || (m_slot < 2 + m_cnt);
  endfunction

  function automatic string pwm_tag();
    if (m_force)      return "R9";
    if (m_slot < 2)   return "R3";
    if (m_slot >= 18) return "R4";
    return "R5 R6";
  endfunction

  task automatic check(string req, bit act, bit exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s slot=%0d actual=%0b expected=%0b", req, m_slot, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check((tag != "") ? tag : pwm_tag(), pwm_o, exp_pwm());
    check((tag != "") ? tag : "R8", period_start_o, m_ps);
  endtask

  // inputs driven at negedge, model steps at posedge, compare at next negedge
  task automatic step(bit tk, logic [9:0] dem, bit frc, string tag = "");
    slot_tick_i = tk; demand_i = dem; force_i = frc;
    @(posedge clk_i);
    m_ps = 0;
    if (tk) begin
      if (m_slot == 19) begin
        m_slot = 0; m_cnt = exp_cnt(dem); m_ps = 1;
      end else m_slot++;
    end
    if (frc) m_force = 1;
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic do_reset();
    rst_ni = 0; slot_tick_i = 0; force_i = 0;
    m_slot = 0; m_cnt = 0; m_force = 0; m_ps = 0;
    repeat (2) @(negedge clk_i);
    compare("R1");
    rst_ni = 1;
    @(negedge clk_i);
    compare("R1");
  endtask

  task automatic run_period(logic [9:0] dem, string tag);
    for (int i = 0; i < 20; i++) step(1, dem, 0, tag);
  endtask

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk_i);
    do_reset();
    // first period after reset has count 0 (R7)
    for (int i = 0; i < 19; i++) step(1, 10'h3FF, 0, "R7");
    // wrap loads 0x3FF -> all 16 high (R5)
    step(1, 10'h3FF, 0, "R8");
    for (int i = 0; i < 19; i++) step(1, 10'h000, 0, "R5");
    step(1, 10'h000, 0, "R5");
    run_period(10'h001, "R5");
    run_period(10'h040, "R6");
    run_period(10'h3C0, "R6");
    run_period(10'h1BF, "R5");
    // demand toggled mid period has no effect (R7)
    for (int i = 0; i < 19; i++) step(1, (i % 2) ? 10'h3FF : 10'h000, 0, "R7");
    step(1, 10'h0C0, 0, "R7");
    // long stretches with the tick held low (R2)
    for (int s = 0; s < 20; s++) begin
      for (int k = 0; k < 5; k++) step(0, 10'($urandom), 0, "R2");
      step(1, 10'h0C0, 0, "R2");
    end
    // constrained random
    for (int i = 0; i < 6000; i++)
      step(($urandom % 3) == 0, 10'($urandom), 0);
    // override latches until reset (R9)
    step(0, 10'h000, 1, "R9");
    for (int i = 0; i < 60; i++) step(1, 10'h000, 0, "R9");
    do_reset();
    run_period(10'h000, "R1");
    run_period(10'h000, "R4");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule